// File: doc/BRIEF.md
# Configuration Word Shadow Loader

This block keeps four 32-bit configuration words in volatile shadow registers and presents them as one 128-bit vector to the rest of the chip. After every reset it reads the words one at a time from a small built-in model of boot nonvolatile storage. The storage is reached through a synchronous read port with one cycle of latency. A done flag stays low until all four words have been captured.

Next to every shadow bit the block keeps its inverted copy. A guard compares the two on every clock once the load has finished. Any disagreement produces a one-cycle request to reset the device. A test input can flip a single inverted bit so that this path can be exercised.

The storage model enforces programming rules. A program operation can only turn bits from 1 to 0. Each word takes at most two program operations until an erase. Values written to storage reach the shadow registers only at the next reset, so the shadow contents cannot change during a power cycle.

Top module: `cfg_shadow_top`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises: `cfg_words` is all ones, `load_done` is 0, `mismatch_rst` is 0 and `prog_err` is 0.
- R2: Logical word i (i = 0..3) is read from byte address 0xBFC0_2FFC − 4·i, so the highest address holds word 0. Word i appears in `cfg_words[32·i+31 : 32·i]`.
- R3: An accepted program of word `prog_sel` with `prog_data` leaves stored value = old value AND `prog_data`. Erased storage is all ones, and no program operation can set a bit back to 1.
- R4: Each stored word accepts at most two program operations. A third is rejected and leaves the word unchanged. `erase_en` sets every word to all ones and restarts every count. An erase wins over a program in the same cycle.
- R5: Once `load_done` is high, `cfg_words` does not change until the next reset, whatever is programmed or erased.
- R6: Counting rising edges with `rst_n` high from release as edge 1, word i is captured on edge i+2 and `load_done` rises on edge 5.
- R7: A disagreement between a shadow bit and its inverted copy, while `load_done` is high, gives `mismatch_rst` high for exactly one cycle, one edge after the disagreement first exists. `inj_en` with `inj_idx` = 32·word + bit flips that one inverted bit on the next edge.
- R8: While `load_done` is low, no disagreement raises `mismatch_rst`. A word captured after a flip of its inverted copy overwrites that flip.
- R9: A rejected program sets `prog_err`. The flag stays high until reset, and only reset clears it.
- R10: Any reset reloads all four words from storage, so values programmed before the reset appear after the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a reload |
| prog_en | input | 1 | Program request for one stored word |
| prog_sel | input | 2 | Logical word to program |
| prog_data | input | 32 | Program mask; 0 bits clear stored bits |
| erase_en | input | 1 | Erase all stored words and restart program counts |
| inj_en | input | 1 | Test: flip one inverted shadow bit |
| inj_idx | input | 7 | Test: flat index of the bit to flip |
| cfg_words | output | 128 | Shadow configuration words, word 0 in the low bits |
| load_done | output | 1 | All four words captured since the last reset |
| mismatch_rst | output | 1 | One-cycle reset request on a shadow/inverted-copy disagreement |
| prog_err | output | 1 | Sticky flag for a rejected program |

## Verification
Every rising edge advances a behavioural model in the bench. The model counts edges since release: it takes a snapshot of a stored word on edge i+1 and moves it into the shadow image on edge i+2. Because of the read register, `load_done` is due on edge 5. The reset request is due one edge after a disagreement becomes visible, and it lasts one cycle. `prog_err` is due on the edge that samples the rejected request. All outputs are compared with the model at the falling edge after each rising edge, once every register on the path has settled. Scenario checks at fixed points cover the reset state, the reload after reprogramming, rejected programs and the masked injections.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and types for the configuration shadow loader.
// Assumes the storage holds exactly the shadowed words at the top of a boot region.
package cfg_pkg;
    localparam int unsigned CFG_WORDS    = 4;
    localparam int unsigned CFG_WBITS    = 32;
    localparam int unsigned CFG_MAXPROG  = 2;
    localparam logic [31:0] CFG_TOP_ADDR = 32'hBFC0_2FFC;
    typedef logic [CFG_WBITS-1:0] cfg_word_t;
endpackage

// File: rtl/cfg_nvm.sv
`timescale 1ns/1ps
// Module: cfg_nvm
// Behavioural model of the boot storage that holds the configuration words.
// It decodes a byte-addressed synchronous read port (one-cycle latency), where the
// highest address holds logical word 0. Programming is clear-only, with a bounded
// count per word; erase restores all ones. Contents survive rst_n. Only the error
// flag is reset. Assumes an erase is issued before the first use.
module cfg_nvm
    import cfg_pkg::*;
#(
    parameter int unsigned NW       = CFG_WORDS,
    parameter int unsigned WB       = CFG_WBITS,
    parameter int unsigned MAXP     = CFG_MAXPROG,
    parameter logic [31:0] TOP_ADDR = CFG_TOP_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [31:0]   rd_addr,
    output logic [WB-1:0] rd_data,
    input  logic          prog_en,
    input  logic [$clog2(NW)-1:0] prog_sel,
    input  logic [WB-1:0] prog_data,
    input  logic          erase_en,
    output logic          prog_err
);
    localparam int unsigned IW = $clog2(NW);
    localparam int unsigned CW = $clog2(MAXP + 1);
    localparam logic [CW-1:0] MAXC = CW'(MAXP);

    logic [WB-1:0] mem_q [NW];
    logic [CW-1:0] cnt_q [NW];
    logic [31:0]   addr_diff;
    logic [IW-1:0] rd_word;
    logic          sel_full;

    assign addr_diff = TOP_ADDR - rd_addr;
    assign rd_word   = addr_diff[IW+1:2];
    assign sel_full  = (cnt_q[prog_sel] >= MAXC);

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic hit;
        assign hit = prog_en && (prog_sel == IW'(w));

        // Storage word update: erase restores ones, accepted program clears bits.
        always_ff @(posedge clk) begin
            if (erase_en) begin
                mem_q[w] <= '1;
                cnt_q[w] <= '0;
            end else if (hit && (cnt_q[w] < MAXC)) begin
                mem_q[w] <= mem_q[w] & prog_data;
                cnt_q[w] <= cnt_q[w] + 1'b1;
            end
        end

        // R3: no stored bit may rise except through an erase.
        p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(erase_en) |-> ((mem_q[w] & ~$past(mem_q[w])) == '0));
        // R4: a program at the limit leaves the word untouched.
        p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hit && !erase_en && (cnt_q[w] >= MAXC)) |-> (mem_q[w] == $past(mem_q[w])));
        // R4: the per-word count never passes the limit.
        p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[w] <= MAXC);
    end

    // Read port: registered data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '1;
        else if (rd_en)
            rd_data <= mem_q[rd_word];
    end

    // Sticky rejection flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_err <= 1'b0;
        else if (prog_en && !erase_en && sel_full)
            prog_err <= 1'b1;
    end

    // R9: once set, the error flag holds until reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> prog_err);
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
// Module: cfg_loader
// After each reset it issues one read per word, word 0 first, and captures each
// returned word into the shadow register and its inverted copy. It raises done
// after the last capture and never reloads until the next reset. A test injection
// flips one inverted bit. Assumes the read port has exactly one cycle of latency.
module cfg_loader
    import cfg_pkg::*;
#(
    parameter int unsigned NW       = CFG_WORDS,
    parameter int unsigned WB       = CFG_WBITS,
    parameter logic [31:0] TOP_ADDR = CFG_TOP_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          rd_en,
    output logic [31:0]   rd_addr,
    input  logic [WB-1:0] rd_data,
    input  logic          inj_en,
    input  logic [$clog2(NW*WB)-1:0] inj_idx,
    output logic [NW*WB-1:0] shadow_o,
    output logic [NW*WB-1:0] comp_o,
    output logic          done_o
);
    localparam int unsigned TB = NW * WB;
    localparam int unsigned IW = $clog2(NW);
    localparam int unsigned SW = $clog2(NW + 1);
    localparam logic [SW-1:0] LAST_STEP = SW'(NW);

    logic [SW-1:0] step_q;
    logic          cap_vld_q;
    logic [IW-1:0] cap_idx_q;
    logic [TB-1:0] inj_mask;

    assign rd_en    = (step_q < LAST_STEP);
    assign rd_addr  = TOP_ADDR - (32'(step_q) << 2);
    assign inj_mask = inj_en ? (TB'(1) << inj_idx) : '0;

    // Read sequencer: one request per cycle until every word is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else if (rd_en)
            step_q <= step_q + 1'b1;
    end

    // Capture tracking: marks which word the read port returns this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_vld_q <= rd_en;
            cap_idx_q <= step_q[IW-1:0];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_shadow
        logic take;
        assign take = cap_vld_q && (cap_idx_q == IW'(w));

        // Shadow word and its inverted copy; capture first, then any injected flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_o[w*WB +: WB] <= '1;
                comp_o[w*WB +: WB]   <= '0;
            end else begin
                if (take)
                    shadow_o[w*WB +: WB] <= rd_data;
                comp_o[w*WB +: WB] <= (take ? ~rd_data : comp_o[w*WB +: WB])
                                      ^ inj_mask[w*WB +: WB];
            end
        end
    end

    // Done flag: set by the capture of the last word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else if (cap_vld_q && (cap_idx_q == IW'(NW - 1)))
            done_o <= 1'b1;
    end

    // R6: done never falls without a reset.
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
    // R6: done rises only on the edge that captured data.
    p_done_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(cap_vld_q));
    // R5: the shadow is frozen once loaded.
    p_shadow_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(shadow_o));
endmodule

// File: rtl/cfg_guard.sv
`timescale 1ns/1ps
// Module: cfg_guard
// Compares every shadow bit with its inverted copy each cycle once armed. It turns
// the first cycle of a disagreement into a registered one-cycle reset request.
// Assumes the loader keeps the inverted copy equal to ~shadow unless a fault occurs.
module cfg_guard #(
    parameter int unsigned TB = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic [TB-1:0] shadow,
    input  logic [TB-1:0] comp,
    output logic          mism_rst
);
    logic mism_now;
    logic mism_q;

    assign mism_now = armed && !(&(shadow ^ comp));

    // Edge detect: request a reset only when a disagreement first appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q   <= 1'b0;
            mism_rst <= 1'b0;
        end else begin
            mism_q   <= mism_now;
            mism_rst <= mism_now && !mism_q;
        end
    end

    // R7: the request lasts one cycle.
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mism_rst |=> !mism_rst);
    // R8: no request follows a cycle in which the guard was not armed.
    p_masked_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !mism_rst);
endmodule

// File: rtl/cfg_shadow_top.sv
`timescale 1ns/1ps
// Module: cfg_shadow_top
// Connects the storage model, the shadow loader and the mismatch guard. It assumes
// reset is held for at least one clock and that no programming happens during a load.
module cfg_shadow_top
    import cfg_pkg::*;
#(
    parameter int unsigned NW       = CFG_WORDS,
    parameter int unsigned WB       = CFG_WBITS,
    parameter int unsigned MAXP     = CFG_MAXPROG,
    parameter logic [31:0] TOP_ADDR = CFG_TOP_ADDR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_en,
    input  logic [$clog2(NW)-1:0]    prog_sel,
    input  logic [WB-1:0]            prog_data,
    input  logic                     erase_en,
    input  logic                     inj_en,
    input  logic [$clog2(NW*WB)-1:0] inj_idx,
    output logic [NW*WB-1:0]         cfg_words,
    output logic                     load_done,
    output logic                     mismatch_rst,
    output logic                     prog_err
);
    localparam int unsigned TB = NW * WB;

    logic          rd_en;
    logic [31:0]   rd_addr;
    logic [WB-1:0] rd_data;
    logic [TB-1:0] comp;

    cfg_nvm #(.NW(NW), .WB(WB), .MAXP(MAXP), .TOP_ADDR(TOP_ADDR)) u_nvm (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .prog_en(prog_en), .prog_sel(prog_sel), .prog_data(prog_data),
        .erase_en(erase_en), .prog_err(prog_err)
    );

    cfg_loader #(.NW(NW), .WB(WB), .TOP_ADDR(TOP_ADDR)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .inj_en(inj_en), .inj_idx(inj_idx),
        .shadow_o(cfg_words), .comp_o(comp), .done_o(load_done)
    );

    cfg_guard #(.TB(TB)) u_guard (
        .clk(clk), .rst_n(rst_n), .armed(load_done),
        .shadow(cfg_words), .comp(comp), .mism_rst(mismatch_rst)
    );

    // R2: the first read after release targets the highest address (word 0).
    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && rd_en) |-> (rd_addr == TOP_ADDR));
endmodule

// File: tb/sim_cfg_shadow_top.sv
`timescale 1ns/1ps
// Bench: drives at falling edges, advances a behavioural model on rising edges,
// and compares every output with the model at each falling edge.
module sim_cfg_shadow_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_en = 1'b0;
    logic [1:0]   prog_sel = '0;
    logic [31:0]  prog_data = '1;
    logic         erase_en = 1'b0;
    logic         inj_en = 1'b0;
    logic [6:0]   inj_idx = '0;
    logic [127:0] cfg_words;
    logic         load_done, mismatch_rst, prog_err;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;
    bit finished = 0;

    cfg_shadow_top u0 (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_sel(prog_sel),
        .prog_data(prog_data), .erase_en(erase_en), .inj_en(inj_en), .inj_idx(inj_idx),
        .cfg_words(cfg_words), .load_done(load_done), .mismatch_rst(mismatch_rst),
        .prog_err(prog_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Behavioural model state
    logic [31:0]  mstore [4];
    int           mcnt [4];
    logic [31:0]  mpend [4];
    logic [127:0] mshadow = '1;
    logic [127:0] mflip = '0;
    bit mdone = 0, mpulse = 0, mprev = 0, merr = 0;
    int k = 0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            mstore[i] = '1;
            mcnt[i] = 0;
            mpend[i] = '1;
        end
    end

    // Model step on every rising edge, using the inputs set at the falling edge before.
    always @(posedge clk) begin
        bit now_mis;
        now_mis = mdone && (mflip != '0);
        if (!rst_n) begin
            k = 0; mshadow = '1; mdone = 0; mflip = '0;
            mpulse = 0; mprev = 0; merr = 0;
        end else begin
            if (k < 4) mpend[k] = mstore[k];
            if (k >= 1 && k <= 4) begin
                mshadow[(k-1)*32 +: 32] = mpend[k-1];
                mflip[(k-1)*32 +: 32] = '0;
            end
            if (k == 4) mdone = 1;
            if (inj_en) mflip[inj_idx] = ~mflip[inj_idx];
            mpulse = now_mis && !mprev;
            mprev = now_mis;
            if (k < 1000) k++;
        end
        if (erase_en) begin
            for (int i = 0; i < 4; i++) begin
                mstore[i] = '1;
                mcnt[i] = 0;
            end
        end else if (prog_en) begin
            if (mcnt[prog_sel] < 2) begin
                mstore[prog_sel] = mstore[prog_sel] & prog_data;
                mcnt[prog_sel]++;
            end else if (rst_n) begin
                merr = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(cfg_words === mshadow, "R2 shadow words", cfg_words, mshadow);
            chk(load_done === mdone, "R6 load_done", 128'(load_done), 128'(mdone));
            chk(mismatch_rst === mpulse, "R7 mismatch_rst", 128'(mismatch_rst), 128'(mpulse));
            chk(prog_err === merr, "R9 prog_err", 128'(prog_err), 128'(merr));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] s, input logic [31:0] d);
        prog_en = 1'b1; prog_sel = s; prog_data = d;
        cyc(1);
        prog_en = 1'b0; prog_data = '1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int pulses;
        // Reset with an erase so storage starts all ones
        erase_en = 1'b1;
        cyc(2);
        erase_en = 1'b0;
        cyc(1);
        cmp_on = 1;
        // R1: reset state
        chk(cfg_words === '1, "R1 words in reset", cfg_words, '1);
        chk(!load_done && !mismatch_rst && !prog_err, "R1 flags in reset",
            128'({load_done, mismatch_rst, prog_err}), 128'(0));
        rst_n = 1'b1;
        cyc(1);
        chk(load_done === 1'b0, "R1 done low after release", 128'(load_done), 128'(0));
        cyc(4);
        // R6: done is due after edge 5, not before
        chk(load_done === 1'b1, "R6 done after five edges", 128'(load_done), 128'(1));
        cyc(3);

        // Program storage; the shadow must not follow (R5)
        prog(2'd0, 32'hFFFF_00FF);
        prog(2'd0, 32'hFFF0_FFFF);
        prog(2'd2, 32'hA5A5_FFFF);
        prog(2'd2, 32'hFFFF_FFFF);
        prog(2'd1, 32'h0F0F_0F0F);
        cyc(2);
        chk(cfg_words === '1, "R5 shadow unchanged by programming", cfg_words, '1);
        // Third program of word 0 is rejected
        prog(2'd0, 32'h0000_0000);
        chk(prog_err === 1'b1, "R4 third program rejected", 128'(prog_err), 128'(1));
        cyc(3);
        chk(prog_err === 1'b1, "R9 error sticky", 128'(prog_err), 128'(1));

        // Reset reloads stored values (R10, R3, R2)
        do_reset();
        chk(prog_err === 1'b0, "R9 error cleared by reset", 128'(prog_err), 128'(0));
        cyc(8);
        chk(cfg_words[31:0] === 32'hFFF0_00FF, "R3 word0 clear-only, third rejected",
            128'(cfg_words[31:0]), 128'(32'hFFF0_00FF));
        chk(cfg_words[95:64] === 32'hA5A5_FFFF, "R3 word2 no bit restored",
            128'(cfg_words[95:64]), 128'(32'hA5A5_FFFF));
        chk(cfg_words[63:32] === 32'h0F0F_0F0F, "R10 word1 reloaded",
            128'(cfg_words[63:32]), 128'(32'h0F0F_0F0F));
        chk(cfg_words[127:96] === 32'hFFFF_FFFF, "R2 word3 position",
            128'(cfg_words[127:96]), 128'(32'hFFFF_FFFF));

        // Injection after load: pulse one edge later, one cycle wide (R7)
        inj_en = 1'b1; inj_idx = 7'd40;
        cyc(1);
        inj_en = 1'b0;
        chk(mismatch_rst === 1'b0, "R7 no pulse on flip edge", 128'(mismatch_rst), 128'(0));
        cyc(1);
        chk(mismatch_rst === 1'b1, "R7 pulse one edge after flip", 128'(mismatch_rst), 128'(1));
        cyc(1);
        chk(mismatch_rst === 1'b0, "R7 pulse single cycle", 128'(mismatch_rst), 128'(0));
        cyc(3);

        // Injections during load (R8)
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        inj_en = 1'b1; inj_idx = 7'd100;   // word 3, captured later: overwritten
        cyc(1);
        inj_idx = 7'd3;                    // word 0, already captured: held until done
        cyc(1);
        inj_en = 1'b0;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            if (!load_done && mismatch_rst) pulses += 100;
            if (mismatch_rst) pulses++;
            cyc(1);
        end
        chk(pulses == 1, "R8 masked during load, one pulse after done",
            128'(pulses), 128'(1));

        // Erase restarts counts: a fresh program is accepted (R4)
        erase_en = 1'b1;
        cyc(1);
        erase_en = 1'b0;
        prog(2'd3, 32'h1234_5678);
        prog(2'd3, 32'hFFFF_FF00);
        chk(prog_err === 1'b0, "R4 counts restart after erase", 128'(prog_err), 128'(0));
        // Erase wins over a simultaneous program
        erase_en = 1'b1; prog_en = 1'b1; prog_sel = 2'd1; prog_data = '0;
        cyc(1);
        erase_en = 1'b0; prog_en = 1'b0; prog_data = '1;
        prog(2'd3, 32'h0000_FFFF);
        do_reset();
        cyc(8);
        chk(cfg_words[127:96] === 32'h0000_FFFF, "R4 erase then program word3",
            128'(cfg_words[127:96]), 128'(32'h0000_FFFF));
        chk(cfg_words[63:32] === 32'hFFFF_FFFF, "R4 erase beats program",
            128'(cfg_words[63:32]), 128'(32'hFFFF_FFFF));
        cyc(2);
        finish_run();
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule